// File: doc/BRIEF.md
# Stream Multicast Fork

This block takes one framed stream that uses a VALID-READY handshake and copies every beat to several destination links. Each beat carries a two-bit frame marker and a payload of several slots, every slot being a presence flag plus a data word. The marker and the payload reach every destination unchanged. The fork decides only which destinations see a live marker in a given cycle and when the source is told that its beat has gone.

Two pacing schemes can be chosen. In master-paced mode, one destination is named the master. It alone sets the pace. The other enabled destinations see the beat only in cycles where the master is ready, and they are expected to take it at once. In collect mode, every enabled destination gets its own live marker. The fork remembers which destinations have already taken the current beat. It releases the source only when every enabled destination has accepted, and a destination that has already taken the beat is not offered it again.

The destination enable mask, the master index and the mode are static inputs. They change only between frames, never inside one.

Top module: `stream_fork`

## Requirements
- R1: The marker codes are 0 idle, 1 head, 2 body and 3 tail. The source offers a beat whenever its marker is not 0. Destination i occupies marker bits [2i+1:2i] and payload bits [i*BEAT_W +: BEAT_W]. Slot k of a beat occupies bits [k*(SLOT_W+1) +: SLOT_W+1], with its flag as the top bit of that range.
- R2: In master-paced mode (cfgMode=0), the master destination sees the source marker in every cycle the source offers a beat, whatever its mask bit.
- R3: In master-paced mode, an enabled non-master destination sees the source marker only while the master's READY is high. Otherwise it sees idle.
- R4: In master-paced mode, srcReady equals the master's READY, and the READYs of the other destinations have no effect on it.
- R5: In collect mode (cfgMode=1), an enabled destination that accepts a beat (live marker and READY at an edge) while the beat is still pending sees idle until that beat completes.
- R6: In collect mode, srcReady is high exactly when every enabled destination not yet recorded has READY high. After that edge all records clear and the next beat is offered to every enabled destination.
- R7: Every destination that sees a live marker sees the source marker value and the full payload bit for bit.
- R8: A destination that is neither enabled nor the master in master-paced mode sees idle, and its READY does not affect srcReady.
- R9: While rstN is low, and after it rises, no acceptance is recorded. An idle source leaves every destination idle.
- R10: Mode, mask and master index stay constant from an accepted head until the matching tail is accepted. A change made between frames takes effect on the next beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgMode | input | 1 | 0 master-paced, 1 collect |
| cfgMask | input | N_DST | Destination enable mask |
| cfgMaster | input | MIDX_W | Master destination index |
| srcMark | input | 2 | Source frame marker |
| srcData | input | BEAT_W | Source payload |
| srcReady | output | 1 | Source beat accepted |
| dstMark | output | 2*N_DST | Per-destination frame markers |
| dstData | output | N_DST*BEAT_W | Per-destination payload copies |
| dstReady | input | N_DST | Per-destination READY |

## Verification
The table walks master-paced frames in which the master is stalled while the other destinations are ready, and the reverse. This separates gating by the master's READY from gating by each destination's own READY. It also covers a master whose mask bit is clear and a mask with gaps, which show that the master is exempt from the mask and that disabled destinations stay idle. Collect-mode beats accepted piecemeal over several cycles, and beats accepted by all destinations in one cycle, separate the recorded acceptances from the live READYs. They also show that records clear once a beat completes. Directed cases cover reset in the middle of a beat and a mode switch between frames.

// File: rtl/fork_pkg.sv
package fork_pkg;
  typedef enum logic [1:0] {
    MARK_IDLE = 2'd0,
    MARK_HEAD = 2'd1,
    MARK_BODY = 2'd2,
    MARK_TAIL = 2'd3
  } frameMark_e;

  typedef enum logic {
    MODE_MASTER = 1'b0,
    MODE_LATCH  = 1'b1
  } forkMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic srcValid;
    logic latchMode;
    logic masterReady;
  } forkStrobe_t;
endpackage

// File: rtl/fork_ctrl.sv
module fork_ctrl
  import fork_pkg::*;
#(
  parameter int N_DST  = 4,
  parameter int MIDX_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgMode,
  input  logic [N_DST-1:0]  cfgMask,
  input  logic [MIDX_W-1:0] cfgMaster,
  input  logic [1:0]        srcMark,
  input  logic [N_DST-1:0]  dstReady,
  output logic              srcReady,
  output logic [N_DST-1:0]  pending,
  output forkStrobe_t       strobe
);
  logic [N_DST-1:0] accepted;
  logic             inFrame;
  logic             srcValid;
  logic             latchMode;
  logic             masterReady;
  logic             allTaken;
  logic             srcFire;

  always_comb begin
    srcValid    = (srcMark != MARK_IDLE);
    latchMode   = (cfgMode == MODE_LATCH);
    masterReady = dstReady[cfgMaster];
    pending     = cfgMask & ~accepted;
    allTaken    = ((pending & ~dstReady) == '0);
    srcReady    = latchMode ? allTaken : masterReady;
    srcFire     = srcValid & srcReady;
    strobe      = '{srcValid: srcValid, latchMode: latchMode, masterReady: masterReady};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accepted <= '0;
      inFrame  <= 1'b0;
    end else begin
      if (!latchMode || srcFire) accepted <= '0;
      else if (srcValid)         accepted <= accepted | (pending & dstReady);
      if (srcFire) begin
        if (srcMark == MARK_HEAD)      inFrame <= 1'b1;
        else if (srcMark == MARK_TAIL) inFrame <= 1'b0;
      end
    end
  end

  // R6: a completing beat must have every enabled destination covered
  a_r6_all_taken: assert property (@(posedge clk) disable iff (!rstN)
    (latchMode && srcFire) |-> (((accepted | dstReady) & cfgMask) == cfgMask));

  // R6: records are empty on the cycle after a completed beat
  a_r6_clear_after: assert property (@(posedge clk) disable iff (!rstN)
    (latchMode && srcFire) |=> (pending == cfgMask));

  // R10: configuration held steady inside a frame
  a_r10_cfg_stable: assert property (@(posedge clk) disable iff (!rstN)
    inFrame |-> $stable({cfgMode, cfgMask, cfgMaster}));
endmodule

// File: rtl/fork_datapath.sv
module fork_datapath
  import fork_pkg::*;
#(
  parameter int N_DST  = 4,
  parameter int MIDX_W = 2,
  parameter int BEAT_W = 36
) (
  input  logic [N_DST-1:0]        cfgMask,
  input  logic [MIDX_W-1:0]       cfgMaster,
  input  logic [N_DST-1:0]        pending,
  input  forkStrobe_t             strobe,
  input  logic [1:0]              srcMark,
  input  logic [BEAT_W-1:0]       srcData,
  output logic [2*N_DST-1:0]      dstMark,
  output logic [N_DST*BEAT_W-1:0] dstData
);
  logic [N_DST-1:0] active;

  for (genvar i = 0; i < N_DST; i++) begin : g_lane
    logic isMaster;
    assign isMaster = (cfgMaster == MIDX_W'(i));
    always_comb begin
      if (strobe.latchMode)
        active[i] = strobe.srcValid & pending[i];
      else if (isMaster)
        active[i] = strobe.srcValid;
      else
        active[i] = strobe.srcValid & cfgMask[i] & strobe.masterReady;
    end
    assign dstMark[2*i +: 2]        = active[i] ? srcMark : MARK_IDLE;
    assign dstData[i*BEAT_W +: BEAT_W] = srcData;
  end
endmodule

// File: rtl/stream_fork.sv
module stream_fork
  import fork_pkg::*;
#(
  parameter int N_DST   = 4,
  parameter int N_SLOTS = 4,
  parameter int SLOT_W  = 8,
  localparam int MIDX_W = (N_DST > 1) ? $clog2(N_DST) : 1,
  localparam int BEAT_W = N_SLOTS * (SLOT_W + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cfgMode,
  input  logic [N_DST-1:0]        cfgMask,
  input  logic [MIDX_W-1:0]       cfgMaster,
  input  logic [1:0]              srcMark,
  input  logic [BEAT_W-1:0]       srcData,
  output logic                    srcReady,
  output logic [2*N_DST-1:0]      dstMark,
  output logic [N_DST*BEAT_W-1:0] dstData,
  input  logic [N_DST-1:0]        dstReady
);
  logic [N_DST-1:0] pending;
  forkStrobe_t      strobe;

  fork_ctrl #(.N_DST(N_DST), .MIDX_W(MIDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .cfgMask(cfgMask),
    .cfgMaster(cfgMaster), .srcMark(srcMark), .dstReady(dstReady),
    .srcReady(srcReady), .pending(pending), .strobe(strobe)
  );

  fork_datapath #(.N_DST(N_DST), .MIDX_W(MIDX_W), .BEAT_W(BEAT_W)) u_dp (
    .cfgMask(cfgMask), .cfgMaster(cfgMaster), .pending(pending),
    .strobe(strobe), .srcMark(srcMark), .srcData(srcData),
    .dstMark(dstMark), .dstData(dstData)
  );

  // R4: master-paced acknowledge follows the master READY
  a_r4_master_ack: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode == MODE_MASTER) |-> (srcReady == dstReady[cfgMaster]));

  for (genvar i = 0; i < N_DST; i++) begin : g_chk
    // R3: secondary lanes only live while master is ready
    a_r3_gated: assert property (@(posedge clk) disable iff (!rstN)
      ((cfgMode == MODE_MASTER) && (cfgMaster != MIDX_W'(i)) && (dstMark[2*i +: 2] != MARK_IDLE))
        |-> dstReady[cfgMaster]);
    // R8: disabled lanes stay idle
    a_r8_disabled_idle: assert property (@(posedge clk) disable iff (!rstN)
      (!cfgMask[i] && !((cfgMode == MODE_MASTER) && (cfgMaster == MIDX_W'(i))))
        |-> (dstMark[2*i +: 2] == MARK_IDLE));
    // R7: live lanes carry the source beat unchanged
    a_r7_copy: assert property (@(posedge clk) disable iff (!rstN)
      (dstMark[2*i +: 2] != MARK_IDLE) |->
        ((dstMark[2*i +: 2] == srcMark) && (dstData[i*BEAT_W +: BEAT_W] == srcData)));
    // R5: an accepted lane is not offered the same pending beat again
    a_r5_no_repeat: assert property (@(posedge clk) disable iff (!rstN)
      ((cfgMode == MODE_LATCH) && (dstMark[2*i +: 2] != MARK_IDLE) && dstReady[i] && !srcReady)
        |=> ((cfgMode != MODE_LATCH) || (dstMark[2*i +: 2] == MARK_IDLE)));
  end
endmodule

// File: tb/tb_stream_fork.sv
module tb_stream_fork;
  import fork_pkg::*;
  localparam int N_DST   = 4;
  localparam int N_SLOTS = 4;
  localparam int SLOT_W  = 8;
  localparam int BEAT_W  = N_SLOTS * (SLOT_W + 1);
  localparam int N_ROWS  = 19;

  logic                    clk = 1'b0;
  logic                    rstN;
  logic                    cfgMode;
  logic [N_DST-1:0]        cfgMask;
  logic [1:0]              cfgMaster;
  logic [1:0]              srcMark;
  logic [BEAT_W-1:0]       srcData;
  logic                    srcReady;
  logic [2*N_DST-1:0]      dstMark;
  logic [N_DST*BEAT_W-1:0] dstData;
  logic [N_DST-1:0]        dstReady;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  stream_fork #(.N_DST(N_DST), .N_SLOTS(N_SLOTS), .SLOT_W(SLOT_W)) dut (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .cfgMask(cfgMask),
    .cfgMaster(cfgMaster), .srcMark(srcMark), .srcData(srcData),
    .srcReady(srcReady), .dstMark(dstMark), .dstData(dstData),
    .dstReady(dstReady)
  );

  // mode, mask, master, mark, ready | expected srcReady, expected live lanes
  localparam logic [17:0] VEC [N_ROWS] = '{
    {1'b0, 4'b1111, 2'd0, 2'd1, 4'b0001, 1'b1, 4'b1111}, // R2 R4 head
    {1'b0, 4'b1111, 2'd0, 2'd2, 4'b1110, 1'b0, 4'b0001}, // R3 R4 master stalled
    {1'b0, 4'b1111, 2'd0, 2'd2, 4'b1111, 1'b1, 4'b1111}, // R3
    {1'b0, 4'b1111, 2'd0, 2'd3, 4'b0000, 1'b0, 4'b0001}, // R3
    {1'b0, 4'b1111, 2'd0, 2'd3, 4'b0001, 1'b1, 4'b1111}, // R4 tail
    {1'b0, 4'b0101, 2'd2, 2'd3, 4'b1011, 1'b0, 4'b0100}, // R4 R8
    {1'b0, 4'b0101, 2'd2, 2'd3, 4'b0100, 1'b1, 4'b0101}, // R3 R8
    {1'b0, 4'b0011, 2'd3, 2'd3, 4'b1000, 1'b1, 4'b1011}, // R2 master unmasked
    {1'b0, 4'b0011, 2'd3, 2'd0, 4'b1111, 1'b1, 4'b0000}, // R1 idle source
    {1'b1, 4'b1111, 2'd0, 2'd1, 4'b0011, 1'b0, 4'b1111}, // R6 partial
    {1'b1, 4'b1111, 2'd0, 2'd1, 4'b0000, 1'b0, 4'b1100}, // R5
    {1'b1, 4'b1111, 2'd0, 2'd1, 4'b0100, 1'b0, 4'b1100}, // R5
    {1'b1, 4'b1111, 2'd0, 2'd1, 4'b1000, 1'b1, 4'b1000}, // R6 completes
    {1'b1, 4'b1111, 2'd0, 2'd3, 4'b1111, 1'b1, 4'b1111}, // R6 cleared
    {1'b1, 4'b0110, 2'd0, 2'd3, 4'b1001, 1'b0, 4'b0110}, // R8
    {1'b1, 4'b0110, 2'd0, 2'd3, 4'b0010, 1'b0, 4'b0110}, // R5
    {1'b1, 4'b0110, 2'd0, 2'd3, 4'b1101, 1'b1, 4'b0100}, // R6 R8
    {1'b1, 4'b0110, 2'd0, 2'd0, 4'b0000, 1'b0, 4'b0000}, // R1
    {1'b0, 4'b1111, 2'd1, 2'd3, 4'b0010, 1'b1, 4'b1111}  // R10 switch back
  };

  function automatic logic [N_DST-1:0] liveLanes();
    logic [N_DST-1:0] m;
    for (int i = 0; i < N_DST; i++) m[i] = (dstMark[2*i +: 2] != 2'd0);
    return m;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic checkCopy(input string req);
    bit ok = 1;
    for (int i = 0; i < N_DST; i++)
      if (dstMark[2*i +: 2] != 2'd0 &&
          (dstMark[2*i +: 2] != srcMark || dstData[i*BEAT_W +: BEAT_W] != srcData)) ok = 0;
    check(ok, req, "payload copy", longint'(dstMark), longint'(srcMark));
  endtask

  initial begin
    #(8 * 5000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; cfgMode = 1'b1; cfgMask = 4'b1111; cfgMaster = 2'd0;
    srcMark = 2'd0; srcData = '0; dstReady = '0;
    repeat (3) @(negedge clk);
    #1;
    check(dstMark == '0, "R9", "idle in reset", longint'(dstMark), 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check(dstMark == '0, "R9", "idle after reset", longint'(dstMark), 0);

    for (int r = 0; r < N_ROWS; r++) begin
      @(negedge clk);
      cfgMode   = VEC[r][17];
      cfgMask   = VEC[r][16:13];
      cfgMaster = VEC[r][12:11];
      srcMark   = VEC[r][10:9];
      dstReady  = VEC[r][8:5];
      srcData   = BEAT_W'(36'h9_3C5A_7E10 ^ (36'h1_1111_1111 * r));
      #1;
      check(srcReady == VEC[r][4], "R4/R6", $sformatf("row %0d srcReady", r),
            longint'(srcReady), longint'(VEC[r][4]));
      check(liveLanes() == VEC[r][3:0], "R2/R3/R5/R8", $sformatf("row %0d live lanes", r),
            longint'(liveLanes()), longint'(VEC[r][3:0]));
      checkCopy("R7");
    end

    // R1: slot flag at top of each slot range reaches every lane
    @(negedge clk);
    cfgMode = 1'b0; cfgMask = 4'b1111; cfgMaster = 2'd0; dstReady = 4'b1111;
    srcMark = 2'd3;
    srcData = {1'b1, 8'hA1, 1'b0, 8'h5B, 1'b1, 8'h00, 1'b0, 8'hFF};
    #1;
    check(dstData[3*BEAT_W + 35] == 1'b1 && dstData[3*BEAT_W + 26] == 1'b0 &&
          dstData[BEAT_W +: 8] == 8'hFF, "R1", "slot layout",
          longint'(dstData[3*BEAT_W +: BEAT_W]), longint'(srcData));
    checkCopy("R7");

    // R9: reset in the middle of a collect beat drops the records
    @(negedge clk);
    srcMark = 2'd0;
    @(negedge clk);
    cfgMode = 1'b1; cfgMask = 4'b1111; srcMark = 2'd1; dstReady = 4'b0001;
    @(negedge clk);
    dstReady = 4'b0000;
    #1;
    check(liveLanes() == 4'b1110, "R5", "lane 0 recorded", longint'(liveLanes()), 4'he);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check(liveLanes() == 4'b1111, "R9", "records cleared by reset", longint'(liveLanes()), 4'hf);
    check(srcReady == 1'b0, "R9", "no ack after reset", longint'(srcReady), 0);

    // R10: mode switch between frames takes effect on the next beat
    @(negedge clk);
    dstReady = 4'b1111;
    srcMark = 2'd3;
    @(negedge clk);
    srcMark = 2'd0;
    @(negedge clk);
    cfgMode = 1'b0; cfgMaster = 2'd2; srcMark = 2'd3; dstReady = 4'b1011;
    #1;
    check(srcReady == 1'b0 && liveLanes() == 4'b0100, "R10", "new master paces",
          longint'({srcReady, liveLanes()}), 5'h04);
    @(negedge clk);
    srcMark = 2'd0;
    #1;
    check(dstMark == '0, "R1", "idle source idles lanes", longint'(dstMark), 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule